// File: doc/BRIEF.md
# SPI Memory Write-Protection Controller

This block holds the command decoder and write-protection state of a serial nonvolatile memory slave with an 8 KB array and 13-bit byte addresses. It watches chip select, serial clock and serial data, sampling them with the system clock. It recognises four single-byte commands: set the write-enable latch, clear it, read the status byte, and write the status byte. The status byte carries a protect-enable bit, two block-protect bits and the write-enable latch.

A separate data path presents the address of a pending array write on `wr_addr`. The block raises `wr_permit` when that write may proceed. The active-low pin `wp_n` guards only status writes, and only while protect-enable is set. It has no effect on array writes. The array, the data path and retention across power cycles are handled elsewhere. Every state bit clears on reset.

Top module: `spi_wp_ctrl`

## Requirements
- R1: Status byte encoding: bit 7 protect-enable, bit 3 BP1, bit 2 BP0, bit 1 write-enable latch; bits 6, 5, 4 and 0 always read 0.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Commands arrive MSB first, sampled on rising serial clock (SPI mode 0), and take effect when chip select returns high.
- R3: A write-status frame (opcode 0x01 followed by one data byte) while the latch is clear changes no status bit.
- R4: While protect-enable is 1 and `wp_n` is low at the end of the frame, a write-status frame changes no status bit. While protect-enable is 0, `wp_n` has no influence.
- R5: An accepted write-status frame loads protect-enable from data bit 7 and BP1:BP0 from data bits 3:2, and clears the latch. Data bits 6:4, 1 and 0 are ignored, so the latch bit cannot be set this way.
- R6: `wr_permit` is 1 only when the latch is set and `wr_addr` lies outside the protected range. BP1:BP0 = 00 protects nothing, 01 protects 0x1800–0x1FFF, 10 protects 0x1000–0x1FFF, and 11 protects the whole array.
- R7: `wp_n` has no effect on `wr_permit`.
- R8: After opcode 0x05, `miso` shifts out the status byte MSB first, changing on falling serial clock. It drives 0 for any later bits and while chip select is high.
- R9: A frame in which chip select rises before the command's last bit (bit 8, or bit 16 for write-status) changes no state.
- R10: After reset the status byte is 0x00 and `wr_permit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select framing each command |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Active-low write-protect pin for status writes |
| wr_addr | input | 13 | Byte address of the pending array write |
| miso | output | 1 | Serial status readback |
| wr_permit | output | 1 | High when the pending array write is allowed |

## Verification
A single write-status frame can, at the moment chip select rises, consume the latch and move the protected boundary. In that same cycle the permit output must respond to the new state. The bench sets the latch with protection off, holds `wr_addr` at 0x0000 and sends a write-status frame that selects full protection. It keeps chip select low after the last data bit and reads `wr_permit` there, expecting 1. It then releases chip select and expects 0 one cycle later. In that case the loss of the latch and the new range both forbid the write.

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl #(
  parameter int          AW      = 13,
  parameter logic [7:0]  OP_WREN = 8'h06,
  parameter logic [7:0]  OP_WRDI = 8'h04,
  parameter logic [7:0]  OP_RDSR = 8'h05,
  parameter logic [7:0]  OP_WRSR = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  input  logic          wp_n,
  input  logic [AW-1:0] wr_addr,
  output logic          miso,
  output logic          wr_permit
);
  localparam logic [4:0]    OPEND = 5'd8;
  localparam logic [4:0]    FREND = 5'd16;
  localparam logic [AW-1:0] LIM_Q = {2'b11, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] LIM_H = {1'b1, {(AW-1){1'b0}}};

  logic       sck_q, cs_q;
  logic [4:0] cnt;
  logic [6:0] sr;
  logic [7:0] op, out_sr, status;
  logic       wel, wpen, d_wpen;
  logic [1:0] bp, d_bp;
  logic       prot;

  wire        rise  = sck & ~sck_q & ~cs_n;
  wire        fall  = ~sck & sck_q & ~cs_n;
  wire        done  = cs_n & ~cs_q;
  wire [7:0]  nxt   = {sr, mosi};
  wire        wr_ok = wel & ~(wpen & ~wp_n);

  assign status    = {wpen, 3'b000, bp, wel, 1'b0};
  assign miso      = out_sr[7];
  assign wr_permit = wel & ~prot;

  always_comb begin
    case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (wr_addr >= LIM_Q);
      2'b10:   prot = (wr_addr >= LIM_H);
      default: prot = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      cnt    <= '0;
      sr     <= '0;
      op     <= '0;
      out_sr <= '0;
      d_wpen <= 1'b0;
      d_bp   <= '0;
      wel    <= 1'b0;
      wpen   <= 1'b0;
      bp     <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        cnt    <= '0;
        out_sr <= '0;
      end else begin
        if (rise) begin
          sr <= nxt[6:0];
          if (cnt != FREND) cnt <= cnt + 5'd1;
          if (cnt == OPEND - 5'd1) op <= nxt;
          if (cnt == FREND - 5'd1) begin
            d_wpen <= nxt[7];
            d_bp   <= nxt[3:2];
          end
        end
        if (fall)
          out_sr <= (cnt == OPEND && op == OP_RDSR) ? status : {out_sr[6:0], 1'b0};
      end
      if (done) begin
        if (cnt >= OPEND && op == OP_WREN) wel <= 1'b1;
        if (cnt >= OPEND && op == OP_WRDI) wel <= 1'b0;
        if (cnt == FREND && op == OP_WRSR && wr_ok) begin
          wpen <= d_wpen;
          bp   <= d_bp;
          wel  <= 1'b0;
        end
      end
    end
  end
endmodule

module spi_wp_ctrl_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wp_n,
  input logic [AW-1:0] wr_addr,
  input logic          miso,
  input logic          wr_permit,
  input logic [7:0]    status
);
  assert_frozen_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(status));

  assert_pin_blocks_wrsr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wp_n) |=> $stable(status[7:2]));

  assert_latch_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status[7:2]) |-> !status[1]);

  assert_full_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !wr_permit);

  assert_upper_quarter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b01 && wr_addr[AW-1:AW-2] == 2'b11) |-> !wr_permit);

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !miso);
endmodule

bind spi_wp_ctrl spi_wp_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wr_addr(wr_addr),
  .miso(miso), .wr_permit(wr_permit), .status(status)
);

// File: tb/spi_wp_ctrl_test.sv
module spi_wp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic [12:0] wr_addr = '0;
  logic        miso, wr_permit;
  int          checks = 0, fails = 0;

  always #5 clk = ~clk;

  spi_wp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .wr_addr(wr_addr), .miso(miso), .wr_permit(wr_permit)
  );

  // {opcode, data, bits sent, wp_n, expected status afterwards}
  localparam logic [29:0] VEC [15] = '{
    {8'h06, 8'h00, 5'd8,  1'b1, 8'h02},   // R2 set latch
    {8'h01, 8'h8C, 5'd16, 1'b1, 8'h8C},   // R5 accept, latch consumed
    {8'h06, 8'h00, 5'd8,  1'b1, 8'h8E},   // R2
    {8'h01, 8'h00, 5'd16, 1'b0, 8'h8E},   // R4 pin blocks
    {8'h01, 8'h04, 5'd16, 1'b1, 8'h04},   // R5 accept with pin high
    {8'h01, 8'h08, 5'd16, 1'b1, 8'h04},   // R3 latch clear -> rejected
    {8'h06, 8'h00, 5'd8,  1'b1, 8'h06},   // R2
    {8'h04, 8'h00, 5'd8,  1'b1, 8'h04},   // R2 clear latch
    {8'h06, 8'h00, 5'd8,  1'b1, 8'h06},   // R2
    {8'h01, 8'h7B, 5'd16, 1'b0, 8'h08},   // R4 pin ignored, R1/R5 fixed and latch bits
    {8'h06, 8'h00, 5'd7,  1'b1, 8'h08},   // R9 truncated set
    {8'h06, 8'h00, 5'd8,  1'b1, 8'h0A},   // R2
    {8'h01, 8'h00, 5'd12, 1'b1, 8'h0A},   // R9 truncated status write
    {8'h04, 8'h00, 5'd5,  1'b1, 8'h0A},   // R9 truncated clear
    {8'h01, 8'h02, 5'd16, 1'b1, 8'h00}    // R5 latch bit in data ignored
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [23:0] bits, input int n, input bit hold,
                       output logic [7:0] last);
    last = '0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = bits[23-i];
      repeat (4) @(negedge clk);
      last = {last[6:0], miso};
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    if (!hold) begin
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic rd_status(output logic [7:0] s);
    frame({8'h05, 16'h0000}, 16, 1'b0, s);
  endtask

  task automatic cmd(input logic [7:0] o, input logic [7:0] d, input int n);
    logic [7:0] dummy;
    frame({o, d, 8'h00}, n, 1'b0, dummy);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 reset state
    chk("R10 permit", {15'd0, wr_permit}, 16'd0);
    chk("R8 idle miso", {15'd0, miso}, 16'd0);
    rd_status(s);
    chk("R10 status", {8'd0, s}, 16'h0000);

    foreach (VEC[k]) begin
      wp_n = VEC[k][8];
      cmd(VEC[k][29:22], VEC[k][21:14], int'(VEC[k][13:9]));
      wp_n = 1'b1;
      rd_status(s);
      chk($sformatf("R1/R2/R3/R4/R5/R9 vector %0d", k), {8'd0, s}, {8'd0, VEC[k][7:0]});
    end

    // R8 exactly one byte then zeros
    cmd(8'h06, 8'h00, 8);
    frame({8'h05, 16'h0000}, 24, 1'b0, s);
    chk("R8 trailing bits", {8'd0, s}, 16'h0000);
    frame({8'h05, 16'h0000}, 16, 1'b0, s);
    chk("R8 status byte", {8'd0, s}, 16'h0002);

    // R6 range map, R7 pin independence; latch set, BP=00
    wr_addr = 13'h1FFF; @(negedge clk);
    chk("R6 bp00 top", {15'd0, wr_permit}, 16'd1);
    wp_n = 1'b0; @(negedge clk);
    chk("R7 pin low", {15'd0, wr_permit}, 16'd1);
    wp_n = 1'b1;
    cmd(8'h04, 8'h00, 8); @(negedge clk);
    chk("R6 no latch", {15'd0, wr_permit}, 16'd0);

    cmd(8'h06, 8'h00, 8); cmd(8'h01, 8'h04, 16); cmd(8'h06, 8'h00, 8);
    wr_addr = 13'h17FF; @(negedge clk);
    chk("R6 bp01 below", {15'd0, wr_permit}, 16'd1);
    wr_addr = 13'h1800; @(negedge clk);
    chk("R6 bp01 edge", {15'd0, wr_permit}, 16'd0);

    cmd(8'h01, 8'h08, 16); cmd(8'h06, 8'h00, 8);
    wr_addr = 13'h0FFF; @(negedge clk);
    chk("R6 bp10 below", {15'd0, wr_permit}, 16'd1);
    wr_addr = 13'h1000; @(negedge clk);
    chk("R6 bp10 edge", {15'd0, wr_permit}, 16'd0);

    // concurrent: status commit and permit at the same edge
    cmd(8'h01, 8'h00, 16); cmd(8'h06, 8'h00, 8);
    wr_addr = 13'h0000; @(negedge clk);
    chk("R6 bp00 bottom", {15'd0, wr_permit}, 16'd1);
    frame({8'h01, 8'h0C, 8'h00}, 16, 1'b1, s);
    chk("R9 before frame end", {15'd0, wr_permit}, 16'd1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5/R6 after commit", {15'd0, wr_permit}, 16'd0);
    cmd(8'h06, 8'h00, 8);
    chk("R6 bp11 with latch", {15'd0, wr_permit}, 16'd0);
    rd_status(s);
    chk("R1 final status", {8'd0, s}, 16'h000E);

    summary();
  end
endmodule